// File: doc/BRIEF.md
# Multiphase On-Pulse Steering Unit

This unit sits between the comparator and on-time logic that decide *when* a high-side pulse must start and the per-phase on-time generators that shape each pulse. Each switching event arrives as a valid/ready transfer with no payload. The unit picks the phase that fires it and emits a one-cycle trigger on that phase. In steady state the phases are served in a fixed circular order, so N active phases end up interleaved by 360/N degrees. When the power state asks for light-load operation, all work collapses onto the first phase.

The unit keeps high-side pulses from overlapping. It watches the high-side busy feedback of every phase and refuses a new event while any phase is conducting. The exception is an undershoot-recovery request, which lifts that rule so pulses may stack. A phase whose valley current limit is active cannot take its turn. The event then waits at the input and is neither dropped nor handed to another phase, so the circular order survives. Back-pressure rule: once `sw_valid` is high it must stay high until a cycle with `sw_ready` high; that cycle is the handshake. `sw_ready` may depend on `sw_valid`-independent inputs only.

The number of active phases is captured when `enable` rises and stays fixed until the next enable cycle. The on-time generator must raise `hs_on` for a phase in the cycle after that phase's trigger.

Top module: `phase_pulse_steer`

## Requirements
- R1: A handshake in cycle t produces exactly one trigger bit in cycle t+1, held for one cycle only; `ph_trig` is never more than one-hot and is all zero in every cycle that does not follow a handshake.
- R2: With the single-phase request low, successive handshakes target phase indices 0, 1, …, K-1, 0, … where K is the captured phase count.
- R3: While `single_req` is high every trigger goes to bit 0. After it falls, rotation restarts at bit 0.
- R4: The phase count is sampled from `cfg_phases` on the cycle `enable` goes from low to high; a value of 0 is taken as 1 and a value above the phase count parameter is taken as that maximum. Changes of `cfg_phases` while enabled have no effect. Bits at or above the captured count never fire.
- R5: With `usr_req` low, `sw_ready` is low in any cycle where some bit of `hs_on` is high or a trigger is being emitted.
- R6: With `usr_req` high, `hs_on` and triggers in flight do not lower `sw_ready`, so pulses on different phases may overlap.
- R7: While `ocp_lim` is high for the phase whose turn it is, `sw_ready` is low; the waiting event later fires on that same phase.
- R8: `sw_ready` is low while `enable` is low and in the first cycle after `enable` rises.
- R9: During reset `ph_trig` is zero and `sw_ready` is low; the rotation restarts at phase 0 and the captured count is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Regulator enable; rising edge captures the phase count |
| cfg_phases | input | CW | Requested number of phases (0 treated as 1) |
| single_req | input | 1 | Light-load request: steer everything to phase 0 |
| usr_req | input | 1 | Undershoot-recovery request: overlap allowed |
| ocp_lim | input | NPH | Per-phase valley current limit active |
| hs_on | input | NPH | Per-phase high-side conduction feedback |
| sw_valid | input | 1 | Switching event pending from the comparator |
| sw_ready | output | 1 | Event accepted this cycle when both are high |
| ph_trig | output | NPH | One-cycle on-pulse start, one bit per phase |

## Verification
Random event streams run against phase counts of one, two and three, including a requested count of zero and a count rewritten while enabled. Streams with sparse current-limit flags reveal whether a blocked turn stalls in place or slips to the next phase. Streams with short and long random on-times and no recovery request show whether the exclusion window covers the trigger cycle as well as the busy feedback. Episodes of the light-load request and of undershoot recovery, including toggling while an event waits, separate a pointer that restarts at phase 0 from one that resumes where it stopped. They also separate an exclusion rule that is truly lifted from one that is only shortened.

// File: rtl/pps_pkg.sv
package pps_pkg;

  // Clamp a requested phase count into 1..maxn.
  function automatic int unsigned fit_count(int unsigned req, int unsigned maxn);
    if (req == 0) return 1;
    if (req > maxn) return maxn;
    return req;
  endfunction

  // Clamp a pointer so it addresses a live phase.
  function automatic int unsigned wrap_idx(int unsigned idx, int unsigned cnt);
    return (idx < cnt) ? idx : 0;
  endfunction

endpackage

// File: rtl/pps_count_latch.sv
module pps_count_latch #(
  parameter int unsigned NPH = 3,
  localparam int unsigned CW = $clog2(NPH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [CW-1:0] cfg_phases,
  output logic          run,
  output logic [CW-1:0] lat_n
);
  import pps_pkg::*;

  logic          run_q;
  logic [CW-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      lat_q <= CW'(1);
    end else begin
      run_q <= enable;
      if (enable && !run_q)
        lat_q <= CW'(fit_count(32'(cfg_phases), NPH));
    end
  end

  assign run   = run_q;
  assign lat_n = lat_q;

  // Count frozen across a continuous enabled stretch.
  p_count_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> $stable(lat_q));

  // Captured count always lies in 1..NPH.
  p_count_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(lat_q) >= 1) && (32'(lat_q) <= NPH));

endmodule

// File: rtl/pps_rotor.sv
module pps_rotor #(
  parameter int unsigned NPH = 3,
  localparam int unsigned CW = $clog2(NPH + 1),
  localparam int unsigned PW = (NPH > 1) ? $clog2(NPH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          live,
  input  logic          single_req,
  input  logic [CW-1:0] lat_n,
  input  logic          take,
  output logic [PW-1:0] tgt
);
  import pps_pkg::*;

  logic [PW-1:0] ptr_q, ptr_d;
  int unsigned   act;
  int unsigned   step;

  always_comb begin
    act  = single_req ? 1 : 32'(lat_n);
    tgt  = single_req ? '0 : PW'(wrap_idx(32'(ptr_q), act));
    step = 32'(tgt) + 1;
    ptr_d = ptr_q;
    if (!live)                 ptr_d = '0;
    else if (take)             ptr_d = (step >= act) ? '0 : PW'(step);
    else if (single_req)       ptr_d = '0;
    else if (32'(ptr_q) >= act) ptr_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // Pointer never addresses a phase beyond the build size.
  p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ptr_q) < NPH);

  // A light-load cycle leaves the pointer at phase 0.
  p_single_rewind_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(single_req) |-> (ptr_q == '0));

endmodule

// File: rtl/pps_gate.sv
module pps_gate #(
  parameter int unsigned NPH = 3,
  localparam int unsigned PW = (NPH > 1) ? $clog2(NPH) : 1
) (
  input  logic           live,
  input  logic           usr_req,
  input  logic [NPH-1:0] hs_on,
  input  logic [NPH-1:0] trig_now,
  input  logic [NPH-1:0] ocp_lim,
  input  logic [PW-1:0]  tgt,
  output logic           rdy
);
  logic quiet;
  logic limited;

  always_comb begin
    quiet   = (hs_on == '0) && (trig_now == '0);
    limited = ocp_lim[tgt];
    rdy     = live && !limited && (usr_req || quiet);
  end

  always_comb begin
    if (rdy && !usr_req) begin
      a_quiet_r5: assert (hs_on == '0);
    end
  end

endmodule

// File: rtl/phase_pulse_steer.sv
module phase_pulse_steer #(
  parameter int unsigned NPH = 3,
  localparam int unsigned CW = $clog2(NPH + 1),
  localparam int unsigned PW = (NPH > 1) ? $clog2(NPH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic [CW-1:0]  cfg_phases,
  input  logic           single_req,
  input  logic           usr_req,
  input  logic [NPH-1:0] ocp_lim,
  input  logic [NPH-1:0] hs_on,
  input  logic           sw_valid,
  output logic           sw_ready,
  output logic [NPH-1:0] ph_trig
);
  logic          run;
  logic [CW-1:0] lat_n;
  logic          live;
  logic [PW-1:0] tgt;
  logic          rdy;
  logic          take;
  logic [NPH-1:0] trig_q;

  assign live = run && enable;
  assign take = sw_valid && rdy;

  pps_count_latch #(.NPH(NPH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_phases(cfg_phases),
    .run(run), .lat_n(lat_n)
  );

  pps_rotor #(.NPH(NPH)) u_rot (
    .clk(clk), .rst_n(rst_n), .live(live), .single_req(single_req),
    .lat_n(lat_n), .take(take), .tgt(tgt)
  );

  pps_gate #(.NPH(NPH)) u_gate (
    .live(live), .usr_req(usr_req), .hs_on(hs_on), .trig_now(trig_q),
    .ocp_lim(ocp_lim), .tgt(tgt), .rdy(rdy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= '0;
    else        trig_q <= take ? (NPH'(1) << tgt) : '0;
  end

  assign sw_ready = rdy;
  assign ph_trig  = trig_q;

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trig_q));

  p_trig_follows_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig_q) |-> $past(sw_valid && sw_ready));

  p_single_bit0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|trig_q) && $past(single_req)) |-> trig_q[0]);

  p_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q >> lat_n) == '0);

  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|trig_q) && !$past(usr_req)) |-> (($past(hs_on) == '0) && ($past(trig_q) == '0)));

  p_limit_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig_q) |-> ((trig_q & $past(ocp_lim)) == '0));

  p_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig_q) |-> ($past(enable) && $past(run)));

endmodule

// File: tb/phase_pulse_steer_tb.sv
module phase_pulse_steer_tb_top;
  localparam int CLK_P = 10;
  localparam int NPH   = 3;
  localparam int CW    = $clog2(NPH + 1);

  logic           clk = 1'b0;
  logic           rst_n;
  logic           enable;
  logic [CW-1:0]  cfg_phases;
  logic           single_req;
  logic           usr_req;
  logic [NPH-1:0] ocp_lim;
  logic [NPH-1:0] hs_on;
  logic           sw_valid;
  logic           sw_ready;
  logic [NPH-1:0] ph_trig;

  int nchk = 0;
  int nfail = 0;
  int hs_cnt [NPH];

  // model state
  bit m_run;
  int m_lat;
  int m_ptr;
  logic [NPH-1:0] m_trig;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  phase_pulse_steer #(.NPH(NPH)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_phases(cfg_phases),
    .single_req(single_req), .usr_req(usr_req), .ocp_lim(ocp_lim),
    .hs_on(hs_on), .sw_valid(sw_valid), .sw_ready(sw_ready), .ph_trig(ph_trig)
  );

  // on-time generator stand-in: busy from the cycle after a trigger
  always @(posedge clk) begin
    for (int p = 0; p < NPH; p++) begin
      if (!rst_n) hs_cnt[p] <= 0;
      else if (ph_trig[p]) hs_cnt[p] <= int'($urandom_range(1, 6));
      else if (hs_cnt[p] > 0) hs_cnt[p] <= hs_cnt[p] - 1;
    end
  end
  always_comb for (int p = 0; p < NPH; p++) hs_on[p] = (hs_cnt[p] != 0);

  task automatic check(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int clampn(int r);
    if (r == 0) return 1;
    if (r > NPH) return NPH;
    return r;
  endfunction

  // one cycle of stimulus plus model; probabilities in per-mille
  task automatic step(bit en, int cfg, int usr_flip, int ocp_pm, int sgl_flip);
    int act, tgt, nxt;
    bit live, rdy, take;
    string tag;
    @(negedge clk);
    check(ph_trig === m_trig, "R2", int'(ph_trig), int'(m_trig));
    enable     = en;
    cfg_phases = CW'(cfg);
    if (int'($urandom_range(0, 999)) < usr_flip) usr_req = ~usr_req;
    if (int'($urandom_range(0, 999)) < sgl_flip) single_req = ~single_req;
    for (int p = 0; p < NPH; p++)
      ocp_lim[p] = (int'($urandom_range(0, 999)) < ocp_pm);
    if (!(sw_valid && !sw_ready)) sw_valid = ($urandom_range(0, 3) != 0);
    #1;
    live = m_run && en;
    act  = single_req ? 1 : m_lat;
    tgt  = single_req ? 0 : ((m_ptr < act) ? m_ptr : 0);
    rdy  = live && !ocp_lim[tgt] && (usr_req || (hs_on == '0 && m_trig == '0));
    if (!live) tag = "R8";
    else if (ocp_lim[tgt]) tag = "R7";
    else if (usr_req) tag = "R6";
    else tag = "R5";
    check(sw_ready === rdy, tag, int'(sw_ready), int'(rdy));
    take = sw_valid && rdy;
    m_trig = take ? (NPH'(1) << tgt) : '0;
    nxt = tgt + 1;
    if (!live) m_ptr = 0;
    else if (take) m_ptr = (nxt >= act) ? 0 : nxt;
    else if (single_req) m_ptr = 0;
    else if (m_ptr >= act) m_ptr = 0;
    if (en && !m_run) m_lat = clampn(cfg);
    m_run = en;
  endtask

  task automatic run_n(int n, bit en, int cfg, int usr_flip, int ocp_pm, int sgl_flip);
    for (int i = 0; i < n; i++) step(en, cfg, usr_flip, ocp_pm, sgl_flip);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; enable = 0; cfg_phases = '0; single_req = 0; usr_req = 0;
    ocp_lim = '0; sw_valid = 0;
    m_run = 0; m_lat = 1; m_ptr = 0; m_trig = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(ph_trig === '0, "R9", int'(ph_trig), 0);
    check(sw_ready === 1'b0, "R9", int'(sw_ready), 0);
    rst_n = 1'b1;
    // R8: disabled, nothing accepted
    run_n(20, 0, 3, 0, 0, 0);
    // R2 three-phase rotation, sparse current limit (R7)
    run_n(800, 1, 3, 0, 60, 0);
    // R4: rewrite count while enabled, must be ignored
    run_n(300, 1, 1, 0, 30, 0);
    // R4: re-enable with two phases
    run_n(10, 0, 2, 0, 0, 0);
    run_n(600, 1, 2, 0, 60, 0);
    // R3 light-load episodes on three phases
    run_n(5, 0, 3, 0, 0, 0);
    run_n(800, 1, 3, 0, 40, 30);
    if (single_req) run_n(1, 1, 3, 0, 0, 1000);
    // R6 undershoot-recovery episodes
    run_n(800, 1, 3, 40, 40, 0);
    if (usr_req) run_n(1, 1, 3, 1000, 0, 0);
    // R4: zero and out-of-range requests
    run_n(5, 0, 0, 0, 0, 0);
    run_n(300, 1, 0, 20, 40, 0);
    // R7: heavy current limiting keeps order
    run_n(5, 0, 3, 0, 0, 0);
    run_n(600, 1, 3, 20, 400, 10);
    // mixed random
    for (int k = 0; k < 10; k++) begin
      int c = int'($urandom_range(0, 3));
      run_n(int'($urandom_range(2, 6)), 0, c, 0, 0, 0);
      run_n(200, 1, c, 30, 80, 20);
    end
    run_n(3, 0, 3, 0, 0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule